// File: doc/BRIEF.md
# Interrupt Arbiter with Delegation

This block keeps the machine-level interrupt state of a hart: a pending register, an enable register and a delegation mask. It also offers supervisor-level windows onto the pending and enable registers that only see the delegated bits. Software sets and clears these registers through a simple write port. A read port returns any of the five views in the same cycle. The machine timer, machine external, supervisor external and coprocessor interrupt lines come straight in as level inputs. A memory-mapped software-interrupt register, written by byte stores, drives the machine software-pending bit.

Each cycle the arbiter decides whether an interrupt is taken. It uses the current privilege level and the two global enable bits. A non-delegated interrupt is eligible under the machine rule, and a delegated one under the supervisor rule. Among the eligible interrupts the lowest bit index wins. The result appears as a strobe and a cause word, with the most significant bit marking an interrupt. The strobe is combinational and is only raised while the core reports an instruction boundary. Updating the trap-entry state is left to the core.

Top module: `irq_arbiter`

## Requirements
- R1: During and right after reset, the pending software bits, the software-interrupt bit, the enable register and the delegation mask are all zero, and no interrupt is taken.
- R2: A write to the machine pending view (select 0) changes only bit 1 (supervisor software) and bit 5 (supervisor timer). Every other pending bit keeps its source.
- R3: A write to the enable view (select 1) stores only bits 1, 3, 5, 7, 9 and 12. A write to the delegation mask (select 2) stores only bits 1, 5, 9 and 12. Write selects 5 to 7 change nothing.
- R4: A read of the supervisor pending view (select 3) returns machine pending AND delegation. A read of the supervisor enable view (select 4) returns machine enable AND delegation. Read selects 5 to 7 return zero.
- R5: A write through select 3 or select 4 modifies only bits that are set in the delegation mask, and is still limited by the masks of R2 and R3.
- R6: A byte store to offset 0 of the software-interrupt register sets pending bit 3 to bit 0 of the byte. A store to any other offset leaves bit 3 unchanged.
- R7: The input lines appear in the pending view in the same cycle: machine timer at bit 7, supervisor external at bit 9, machine external at bit 11, coprocessor at bit 12.
- R8: A pending and enabled interrupt whose delegation bit is clear is eligible when privilege (U=0, S=1, M=3) is below M. It is also eligible when privilege is M and the machine global enable is set.
- R9: A pending and enabled interrupt whose delegation bit is set is eligible when privilege is U. It is also eligible when privilege is S and the supervisor global enable is set. It is never eligible at M.
- R10: If any interrupt is eligible, the cause output is the lowest eligible bit index with bit XLEN-1 set.
- R11: The take strobe is high exactly when some interrupt is eligible and the instruction-boundary input is high. The cause output is zero whenever the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wsel | input | 3 | Write view: 0 mpend, 1 menable, 2 deleg, 3 spend, 4 senable |
| csr_wdata | input | NIRQ | Write data |
| csr_rsel | input | 3 | Read view, same encoding |
| csr_rdata | output | NIRQ | Read data of the selected view |
| msip_st_valid | input | 1 | Byte store to the software-interrupt register |
| msip_st_off | input | OFF_W | Byte offset of the store |
| msip_st_byte | input | 8 | Stored byte |
| mtimer_irq | input | 1 | Machine timer line |
| mext_irq | input | 1 | Machine external line |
| sext_irq | input | 1 | Supervisor external line |
| cop_irq | input | 1 | Coprocessor line |
| priv | input | 2 | Current privilege level |
| m_glb_en | input | 1 | Machine global interrupt enable |
| s_glb_en | input | 1 | Supervisor global interrupt enable |
| insn_bound | input | 1 | Core is at an instruction boundary |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_cause | output | XLEN | Cause code with interrupt flag |

## Verification
Register writes and software-interrupt stores take effect at the clock edge that samples them. Their readback and arbitration effects are due in the cycle right after that edge. The input lines, privilege, global enables and boundary input act on the strobe, the cause and the read data in the same cycle, with no register on the way. The bench drives every input at the falling edge and samples all three outputs one time step later, before the next rising edge. It updates its model of the registers only after that rising edge, so each sample is compared with the state of the current cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } view_sel_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // interrupt bit positions; the cause code is the bit index
  localparam int unsigned B_SSW  = 1;
  localparam int unsigned B_MSW  = 3;
  localparam int unsigned B_STM  = 5;
  localparam int unsigned B_MTM  = 7;
  localparam int unsigned B_SEXT = 9;
  localparam int unsigned B_MEXT = 11;
  localparam int unsigned B_COP  = 12;

endpackage

// File: rtl/irq_view_regs.sv
module irq_view_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [2:0]      csr_wsel,
  input  logic [NIRQ-1:0] csr_wdata,
  input  logic [2:0]      csr_rsel,
  input  logic [NIRQ-1:0] pend_full,
  output logic [NIRQ-1:0] swpend_q,
  output logic [NIRQ-1:0] en_q,
  output logic [NIRQ-1:0] deleg_q,
  output logic [NIRQ-1:0] csr_rdata
);

  localparam logic [NIRQ-1:0] SWP_MSK = (NIRQ'(1) << B_SSW) | (NIRQ'(1) << B_STM);
  localparam logic [NIRQ-1:0] DLG_MSK = SWP_MSK | (NIRQ'(1) << B_SEXT) | (NIRQ'(1) << B_COP);
  localparam logic [NIRQ-1:0] EN_MSK  = DLG_MSK | (NIRQ'(1) << B_MSW) | (NIRQ'(1) << B_MTM);

  logic [NIRQ-1:0] swpend_d, en_d, deleg_d;
  logic [NIRQ-1:0] sp_msk, se_msk;
  view_sel_e       wsel, rsel;

  assign wsel   = view_sel_e'(csr_wsel);
  assign rsel   = view_sel_e'(csr_rsel);
  assign sp_msk = SWP_MSK & deleg_q;
  assign se_msk = EN_MSK & deleg_q;

  always_comb begin
    swpend_d = swpend_q;
    en_d     = en_q;
    deleg_d  = deleg_q;
    case (wsel)
      SEL_MPEND: swpend_d = (swpend_q & ~SWP_MSK) | (csr_wdata & SWP_MSK);
      SEL_MEN:   en_d     = (en_q & ~EN_MSK) | (csr_wdata & EN_MSK);
      SEL_DELEG: deleg_d  = (deleg_q & ~DLG_MSK) | (csr_wdata & DLG_MSK);
      SEL_SPEND: swpend_d = (swpend_q & ~sp_msk) | (csr_wdata & sp_msk);
      SEL_SEN:   en_d     = (en_q & ~se_msk) | (csr_wdata & se_msk);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swpend_q <= '0;
      en_q     <= '0;
      deleg_q  <= '0;
    end else if (csr_we) begin
      swpend_q <= swpend_d;
      en_q     <= en_d;
      deleg_q  <= deleg_d;
    end
  end

  always_comb begin
    case (rsel)
      SEL_MPEND: csr_rdata = pend_full;
      SEL_MEN:   csr_rdata = en_q;
      SEL_DELEG: csr_rdata = deleg_q;
      SEL_SPEND: csr_rdata = pend_full & deleg_q;
      SEL_SEN:   csr_rdata = en_q & deleg_q;
      default:   csr_rdata = '0;
    endcase
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ($stable(en_q) && $stable(deleg_q) && $stable(swpend_q)));

  // R5
  sen_deleg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && wsel == SEL_SEN) |=> (((en_q ^ $past(en_q)) & ~$past(deleg_q)) == '0));

  // R5
  spend_deleg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && wsel == SEL_SPEND) |=> (((swpend_q ^ $past(swpend_q)) & ~$past(deleg_q)) == '0));

endmodule

// File: rtl/irq_msip_reg.sv
module irq_msip_reg #(
  parameter int unsigned OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [OFF_W-1:0] st_off,
  input  logic [7:0]       st_byte,
  output logic             msip_q
);

  logic hit;
  logic msip_d;
  logic byte_unused;

  assign hit         = st_valid && (st_off == '0);
  assign byte_unused = ^st_byte[7:1];

  always_comb begin
    msip_d = msip_q;
    if (hit) msip_d = st_byte[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   msip_q <= 1'b0;
    else if (hit) msip_q <= msip_d;
  end

  // R6
  msip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && st_off == '0) |=> $stable(msip_q));

  // R6
  msip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_off == '0) |=> (msip_q == $past(st_byte[0])));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] active,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            m_glb_en,
  input  logic            s_glb_en,
  input  logic            insn_bound,
  output logic            irq_take,
  output logic [XLEN-1:0] irq_cause
);

  localparam int unsigned IDX_W = $clog2(NIRQ);

  logic            m_ok, s_ok;
  logic [NIRQ-1:0] elig;
  logic [IDX_W-1:0] idx;

  assign m_ok = (priv < PRIV_M) || ((priv == PRIV_M) && m_glb_en);
  assign s_ok = (priv < PRIV_S) || ((priv == PRIV_S) && s_glb_en);

  for (genvar g = 0; g < NIRQ; g++) begin : g_elig
    assign elig[g] = active[g] && (deleg[g] ? s_ok : m_ok);
  end

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end

  assign irq_take  = insn_bound && (|elig);
  assign irq_cause = irq_take ? ({1'b1, {(XLEN-1){1'b0}}} | XLEN'(idx)) : '0;

  // R10
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((elig & (~elig + NIRQ'(1))) == (NIRQ'(1) << irq_cause[IDX_W-1:0])));

  // R8
  mlevel_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !deleg[irq_cause[IDX_W-1:0]]) |-> (priv != PRIV_M || m_glb_en));

  // R9
  slevel_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && deleg[irq_cause[IDX_W-1:0]]) |->
      (priv == PRIV_U || (priv == PRIV_S && s_glb_en)));

  // R11
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_cause[XLEN-1]);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NIRQ  = 16,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [2:0]       csr_wsel,
  input  logic [NIRQ-1:0]  csr_wdata,
  input  logic [2:0]       csr_rsel,
  output logic [NIRQ-1:0]  csr_rdata,
  input  logic             msip_st_valid,
  input  logic [OFF_W-1:0] msip_st_off,
  input  logic [7:0]       msip_st_byte,
  input  logic             mtimer_irq,
  input  logic             mext_irq,
  input  logic             sext_irq,
  input  logic             cop_irq,
  input  logic [1:0]       priv,
  input  logic             m_glb_en,
  input  logic             s_glb_en,
  input  logic             insn_bound,
  output logic             irq_take,
  output logic [XLEN-1:0]  irq_cause
);

  logic [NIRQ-1:0] swpend_q, en_q, deleg_q, pend_full;
  logic            msip_q;

  always_comb begin
    pend_full         = swpend_q;
    pend_full[B_MSW]  = msip_q;
    pend_full[B_MTM]  = mtimer_irq;
    pend_full[B_SEXT] = sext_irq;
    pend_full[B_MEXT] = mext_irq;
    pend_full[B_COP]  = cop_irq;
  end

  irq_view_regs #(.NIRQ(NIRQ)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wsel  (csr_wsel),
    .csr_wdata (csr_wdata),
    .csr_rsel  (csr_rsel),
    .pend_full (pend_full),
    .swpend_q  (swpend_q),
    .en_q      (en_q),
    .deleg_q   (deleg_q),
    .csr_rdata (csr_rdata)
  );

  irq_msip_reg #(.OFF_W(OFF_W)) u_msip (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (msip_st_valid),
    .st_off   (msip_st_off),
    .st_byte  (msip_st_byte),
    .msip_q   (msip_q)
  );

  irq_pick #(.NIRQ(NIRQ), .XLEN(XLEN)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (pend_full & en_q),
    .deleg      (deleg_q),
    .priv       (priv),
    .m_glb_en   (m_glb_en),
    .s_glb_en   (s_glb_en),
    .insn_bound (insn_bound),
    .irq_take   (irq_take),
    .irq_cause  (irq_cause)
  );

  // R7
  line_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rsel == 3'd0) |-> (csr_rdata[B_MTM] == mtimer_irq && csr_rdata[B_MEXT] == mext_irq));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (en_q == '0 && deleg_q == '0 && !msip_q));

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;

  localparam logic [15:0] SWP = 16'h0022;
  localparam logic [15:0] DLM = 16'h1222;
  localparam logic [15:0] ENM = 16'h12AA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [2:0]  csr_wsel, csr_rsel;
  logic [15:0] csr_wdata, csr_rdata;
  logic        st_v;
  logic [3:0]  st_off;
  logic [7:0]  st_b;
  logic        mtm, mext, sext, cop;
  logic [1:0]  priv;
  logic        mg, sg, bd;
  logic        irq_take;
  logic [31:0] irq_cause;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_sw, m_en, m_dl;
  logic        m_msip;

  always #5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wsel(csr_wsel),
    .csr_wdata(csr_wdata), .csr_rsel(csr_rsel), .csr_rdata(csr_rdata),
    .msip_st_valid(st_v), .msip_st_off(st_off), .msip_st_byte(st_b),
    .mtimer_irq(mtm), .mext_irq(mext), .sext_irq(sext), .cop_irq(cop),
    .priv(priv), .m_glb_en(m_glb_en_w), .s_glb_en(sg), .insn_bound(bd),
    .irq_take(irq_take), .irq_cause(irq_cause)
  );
  wire m_glb_en_w = mg;

  function automatic logic [15:0] e_pend();
    logic [15:0] p;
    p = m_sw;
    p[3] = m_msip; p[7] = mtm; p[9] = sext; p[11] = mext; p[12] = cop;
    return p;
  endfunction

  function automatic logic [15:0] e_rdata();
    case (csr_rsel)
      3'd0: return e_pend();
      3'd1: return m_en;
      3'd2: return m_dl;
      3'd3: return e_pend() & m_dl;
      3'd4: return m_en & m_dl;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [31:0] e_cause();
    logic [15:0] act, el;
    logic mok, sok;
    act = e_pend() & m_en;
    mok = (priv == 2'd0) || (priv == 2'd1) || (priv == 2'd2) || (priv == 2'd3 && mg);
    sok = (priv == 2'd0) || (priv == 2'd1 && sg);
    el  = (act & ~m_dl & {16{mok}}) | (act & m_dl & {16{sok}});
    if (!bd || el == 16'h0) return 32'h0;
    for (int i = 0; i < 16; i++) if (el[i]) return 32'h8000_0000 | 32'(i);
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_upd();
    logic [15:0] m;
    if (csr_we) begin
      case (csr_wsel)
        3'd0: m_sw = (m_sw & ~SWP) | (csr_wdata & SWP);
        3'd1: m_en = (m_en & ~ENM) | (csr_wdata & ENM);
        3'd2: m_dl = (m_dl & ~DLM) | (csr_wdata & DLM);
        3'd3: begin m = SWP & m_dl; m_sw = (m_sw & ~m) | (csr_wdata & m); end
        3'd4: begin m = ENM & m_dl; m_en = (m_en & ~m) | (csr_wdata & m); end
        default: ;
      endcase
    end
    if (st_v && st_off == 4'd0) m_msip = st_b[0];
  endtask

  // inputs are set at the falling edge before calling this
  task automatic tick(input string lbl);
    #1;
    chk({lbl, " take"}, 32'(irq_take), 32'(e_cause() != 32'h0));
    chk({lbl, " cause"}, irq_cause, e_cause());
    chk({lbl, " rdata"}, 32'(csr_rdata), 32'(e_rdata()));
    @(posedge clk);
    model_upd();
    @(negedge clk);
    csr_we = 1'b0; st_v = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d, input string lbl);
    csr_we = 1'b1; csr_wsel = s; csr_wdata = d;
    tick(lbl);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; csr_we = 0; csr_wsel = 0; csr_wdata = 0; csr_rsel = 0;
    st_v = 0; st_off = 0; st_b = 0; mtm = 0; mext = 0; sext = 0; cop = 0;
    priv = 2'd3; mg = 1; sg = 1; bd = 1;
    m_sw = 0; m_en = 0; m_dl = 0; m_msip = 0;
    repeat (3) @(negedge clk);
    // R1 reset state across all views
    for (int s = 0; s < 5; s++) begin
      csr_rsel = 3'(s); #1;
      chk("R1 reset view", 32'(csr_rdata), 32'h0);
    end
    chk("R1 reset take", 32'(irq_take), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    csr_rsel = 3'd1; tick("R1 after release");

    // R3 enable and delegation masks
    csr_rsel = 3'd1; wr(3'd1, 16'hFFFF, "R3 en write");
    #1 chk("R3 en mask", 32'(csr_rdata), 32'(ENM));
    csr_rsel = 3'd2; wr(3'd2, 16'hFFFF, "R3 deleg write");
    #1 chk("R3 deleg mask", 32'(csr_rdata), 32'(DLM));
    wr(3'd6, 16'h0000, "R3 bad select");
    #1 chk("R3 bad select ignored", 32'(csr_rdata), 32'(DLM));
    // R4 supervisor views
    csr_rsel = 3'd4; #1 chk("R4 sen view", 32'(csr_rdata), 32'(ENM & DLM));
    csr_rsel = 3'd7; #1 chk("R4 unused select", 32'(csr_rdata), 32'h0);
    // R2 pending write mask; mask interrupts off while inspecting
    priv = 2'd3; mg = 0; sg = 0;
    csr_rsel = 3'd0; wr(3'd0, 16'hFFFF, "R2 pend write");
    #1 chk("R2 only sw bits", 32'(csr_rdata), 32'(SWP));
    // R5 supervisor writes only touch delegated bits
    wr(3'd2, 16'h0002, "R5 deleg ssw only");
    wr(3'd3, 16'h0000, "R5 spend clear");
    #1 chk("R5 spend write", 32'(csr_rdata), 32'h0020);
    csr_rsel = 3'd1; wr(3'd4, 16'h0000, "R5 sen clear");
    #1 chk("R5 sen write", 32'(csr_rdata), 32'(ENM & ~16'h0002));
    // R6 software-interrupt register
    csr_rsel = 3'd0;
    st_v = 1; st_off = 4'd1; st_b = 8'h01; tick("R6 other offset");
    #1 chk("R6 offset ignored", 32'(csr_rdata[3]), 32'h0);
    st_v = 1; st_off = 4'd0; st_b = 8'hFF; tick("R6 set");
    #1 chk("R6 set bit3", 32'(csr_rdata[3]), 32'h1);
    st_v = 1; st_off = 4'd0; st_b = 8'hFE; tick("R6 clear");
    #1 chk("R6 cleared bit3", 32'(csr_rdata[3]), 32'h0);
    // R7 lines
    mtm = 1; mext = 1; sext = 1; cop = 1; #1
    chk("R7 lines", 32'(csr_rdata & 16'h1A80), 32'h1A80);
    mtm = 0; mext = 0; sext = 0; cop = 0;
    // R8: stpend(bit5) not delegated, enabled
    wr(3'd1, ENM, "R8 enable all");
    priv = 2'd3; mg = 0; #1 chk("R8 M no mg", 32'(irq_take), 32'h0);
    mg = 1; #1 chk("R8 M with mg", irq_cause, 32'h8000_0005);
    priv = 2'd1; mg = 0; #1 chk("R8 below M", irq_cause, 32'h8000_0005);
    // R9: delegate bit5, ssw cleared so bit5 alone
    wr(3'd2, 16'h0020, "R9 deleg stm");
    priv = 2'd3; mg = 1; sg = 1; #1 chk("R9 never at M", 32'(irq_take), 32'h0);
    priv = 2'd1; sg = 0; #1 chk("R9 S no sg", 32'(irq_take), 32'h0);
    sg = 1; #1 chk("R9 S with sg", irq_cause, 32'h8000_0005);
    priv = 2'd0; sg = 0; #1 chk("R9 at U", irq_cause, 32'h8000_0005);
    // R10 lowest wins: set ssw too, undelegated
    wr(3'd0, 16'h0022, "R10 both pending");
    priv = 2'd0; #1 chk("R10 lowest", irq_cause, 32'h8000_0001);
    // R11 boundary gating
    bd = 0; #1 chk("R11 no boundary take", 32'(irq_take), 32'h0);
    chk("R11 no boundary cause", irq_cause, 32'h0);
    bd = 1; tick("R11 boundary back");

    // random mix, checked each cycle against the model (R2..R11)
    for (int n = 0; n < 600; n++) begin
      csr_we    = ($urandom % 3) == 0;
      csr_wsel  = 3'($urandom % 6);
      csr_wdata = 16'($urandom);
      csr_rsel  = 3'($urandom % 6);
      case ($urandom % 3)
        0: priv = 2'd0;
        1: priv = 2'd1;
        default: priv = 2'd3;
      endcase
      mg = 1'($urandom); sg = 1'($urandom); bd = ($urandom % 4) != 0;
      mtm = 1'($urandom); mext = 1'($urandom); sext = 1'($urandom); cop = 1'($urandom);
      st_v = ($urandom % 4) == 0; st_off = 4'($urandom % 2); st_b = 8'($urandom);
      tick("R8 R9 R10 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule